// File: doc/BRIEF.md
# Uncorrectable Error Header Log With Pending Queue

This block keeps the logging state for uncorrectable errors: an uncorrectable status vector, a pointer to the first error that was logged, a header log of four 32-bit words and a prefix log of four 32-bit words. A record request carries a one-hot error status, the header and prefix words, and one valid flag for each of the two word groups. When the multiple-header mode is off, each new record overwrites the logs. When the mode is on and the error that is currently logged is still pending in the status vector, the new record goes into a small circular queue instead.

Software clears status bits with write-1-to-clear writes. Clearing the bit that the first-error pointer names retires the logged error. If an error is waiting in the queue, the oldest one moves into the logs. Otherwise the logs are cleared. The status bits of errors that are still queued cannot be cleared while those errors wait. A write to the control register sets the mode and empties the queue. When a record finds the queue full, the record is dropped and a one-cycle overflow pulse is raised. Logic outside this block turns that pulse into a correctable error.

Top module: `err_hdr_log`

## Requirements
- R1: During reset and after it, the status vector, mode, pointer, both logs, the prefix-present flag and the overflow pulse are all zero.
- R2: A record that is logged loads the pointer with the index of the lowest set bit of its status. A record always sets its status bits in the status vector, whether it is logged, queued or dropped.
- R3: On a logged record, the header log takes the four header words (word 0 in bits 31:0) when the header-valid flag is 1. When the flag is 0, the header log is zero.
- R4: The prefix log takes the prefix words, and the prefix-present flag goes to 1, only when the prefix-valid flag and the prefix enable input are both 1 at load time. Otherwise the prefix log is zero and the flag is 0.
- R5: With the mode on, a record is queued instead of logged when the status bit named by the pointer is set. The logs and the pointer do not change.
- R6: A record that should be queued while the queue holds DEPTH entries is dropped. `overflow_o` is 1 for exactly the next cycle, and the logs do not change.
- R7: A status write that leaves the pointed bit at 0, when the mode is off or the queue is empty, clears the pointer, both logs and the prefix-present flag.
- R8: A status write that leaves the pointed bit at 0, when the mode is on and the queue is not empty, sets again the status bits of every queued entry and loads the oldest entry into the logs. Entries leave the queue in arrival order.
- R9: A status write that leaves the pointed bit at 1, with the mode on, sets again the status bits of all queued entries.
- R10: A control write loads the mode from `ctl_mhre_i` and empties the queue.
- R11: Events that arrive in the same cycle are applied in this order: the control write, then the status write, then the record.
- R12: Every output changes on the first rising clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record request |
| rec_status_i | input | NUM_ERR | One-hot error status of the record |
| rec_hdr_i | input | 128 | Header words; word k is in bits 32k+31:32k |
| rec_pfx_i | input | 128 | Prefix words, same layout as the header words |
| rec_hdr_vld_i | input | 1 | Header words are valid |
| rec_pfx_vld_i | input | 1 | Prefix words are present |
| pfx_en_i | input | 1 | End-to-end prefix enable |
| sta_wr_i | input | 1 | Write to the status vector |
| sta_wdata_i | input | NUM_ERR | Write-1-to-clear mask |
| ctl_wr_i | input | 1 | Write to the control register |
| ctl_mhre_i | input | 1 | New value of the multiple-header mode |
| status_o | output | NUM_ERR | Uncorrectable status vector |
| mhre_o | output | 1 | Multiple-header mode |
| fep_o | output | IDX_W | First-error pointer |
| hdr_log_o | output | 128 | Header log |
| pfx_log_o | output | 128 | Prefix log |
| pfx_present_o | output | 1 | Prefix log holds valid words |
| overflow_o | output | 1 | One-cycle pulse when a record is dropped |

## Verification
The bench builds the block with NUM_ERR = 16 and DEPTH = 3. With a queue that shallow, a fourth pending error reaches the full-queue drop after only a few records. A 16-bit status vector makes it likely that the random phase hits the same bit twice, clears the pointed bit, and writes the status in the same cycle as a record. The random phase also sends control writes that land between pops, so it covers flushes while errors are still queued.

// File: rtl/err_hdr_pkg.sv
package err_hdr_pkg;
  localparam int LOG_WORDS = 4;
  localparam int WORD_W    = 32;
  localparam int LOG_W     = LOG_WORDS * WORD_W;

  typedef struct packed {
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
    logic             hdr_vld;
    logic             pfx_vld;
  } payload_t;
endpackage

// File: rtl/err_hdr_lsb_enc.sv
module err_hdr_lsb_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/err_hdr_fifo.sv
module err_hdr_fifo
  import err_hdr_pkg::*;
#(
  parameter int NUM_ERR = 32,
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 5,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic [IDX_W-1:0]   push_idx_i,
  input  payload_t           push_pl_i,
  input  logic               pop_i,
  output logic [IDX_W-1:0]   head_idx_o,
  output payload_t           head_pl_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [NUM_ERR-1:0] busy_mask_o
);
  localparam int QP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] idx_mem [DEPTH];
  payload_t         pl_mem  [DEPTH];
  logic [QP_W-1:0]  rd_q, wr_q, rd_b, wr_b;
  logic [CNT_W-1:0] cnt_q, cnt_b;
  logic [DEPTH-1:0] occ;

  function automatic logic [QP_W-1:0] inc(input logic [QP_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign rd_b = flush_i ? '0 : rd_q;
  assign wr_b = flush_i ? '0 : wr_q;
  assign cnt_b = flush_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        idx_mem[i] <= '0;
        pl_mem[i]  <= '0;
      end
    end else begin
      rd_q  <= pop_i ? inc(rd_b) : rd_b;
      wr_q  <= push_i ? inc(wr_b) : wr_b;
      cnt_q <= cnt_b - CNT_W'(pop_i) + CNT_W'(push_i);
      if (push_i) begin
        idx_mem[wr_b] <= push_idx_i;
        pl_mem[wr_b]  <= push_pl_i;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    assign occ[g] = ((g + DEPTH - int'(rd_q)) % DEPTH) < int'(cnt_q);
  end

  always_comb begin
    busy_mask_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ[i]) busy_mask_o[idx_mem[i]] = 1'b1;
    end
  end

  assign head_idx_o = idx_mem[rd_q];
  assign head_pl_o  = pl_mem[rd_q];
  assign cnt_o      = cnt_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  // R6
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i && !pop_i) |-> (int'(cnt_q) < DEPTH));
endmodule

// File: rtl/err_hdr_log_regs.sv
module err_hdr_log_regs
  import err_hdr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  payload_t         ld_pl_i,
  input  logic             pfx_en_i,
  output logic [IDX_W-1:0] fep_o,
  output logic [LOG_W-1:0] hdr_o,
  output logic [LOG_W-1:0] pfx_o,
  output logic             pfx_present_o
);
  logic pfx_take;
  assign pfx_take = ld_pl_i.pfx_vld && pfx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fep_o         <= '0;
      hdr_o         <= '0;
      pfx_o         <= '0;
      pfx_present_o <= 1'b0;
    end else if (ld_i) begin
      fep_o         <= ld_idx_i;
      hdr_o         <= ld_pl_i.hdr_vld ? ld_pl_i.hdr : '0;
      pfx_o         <= pfx_take ? ld_pl_i.pfx : '0;
      pfx_present_o <= pfx_take;
    end else if (clr_i) begin
      fep_o         <= '0;
      hdr_o         <= '0;
      pfx_o         <= '0;
      pfx_present_o <= 1'b0;
    end
  end

  // R4
  pfx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pfx_present_o) |-> $past(ld_i && pfx_en_i));
endmodule

// File: rtl/err_hdr_log.sv
module err_hdr_log
  import err_hdr_pkg::*;
#(
  parameter int NUM_ERR = 32,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rec_valid_i,
  input  logic [NUM_ERR-1:0] rec_status_i,
  input  logic [LOG_W-1:0]   rec_hdr_i,
  input  logic [LOG_W-1:0]   rec_pfx_i,
  input  logic               rec_hdr_vld_i,
  input  logic               rec_pfx_vld_i,
  input  logic               pfx_en_i,
  input  logic               sta_wr_i,
  input  logic [NUM_ERR-1:0] sta_wdata_i,
  input  logic               ctl_wr_i,
  input  logic               ctl_mhre_i,
  output logic [NUM_ERR-1:0] status_o,
  output logic               mhre_o,
  output logic [IDX_W-1:0]   fep_o,
  output logic [LOG_W-1:0]   hdr_log_o,
  output logic [LOG_W-1:0]   pfx_log_o,
  output logic               pfx_present_o,
  output logic               overflow_o
);
  logic [NUM_ERR-1:0] status_q, sta_clr, sta_b, q_mask, mask_a;
  logic               mhre_q, mhre_a, ovf_q;
  logic [CNT_W-1:0]   q_cnt, cnt_a, cnt_b;
  logic [IDX_W-1:0]   head_idx, rec_idx, fep_b, ld_idx;
  payload_t           head_pl, rec_pl, ld_pl;
  logic fep_hit, do_clear, do_pop, restore, queue_hit, do_push, drop, rec_log;

  err_hdr_lsb_enc #(.N(NUM_ERR), .IDX_W(IDX_W)) u_enc (
    .vec_i (rec_status_i),
    .idx_o (rec_idx)
  );

  assign rec_pl = '{hdr: rec_hdr_i, pfx: rec_pfx_i,
                    hdr_vld: rec_hdr_vld_i, pfx_vld: rec_pfx_vld_i};

  // control write first
  assign mhre_a = ctl_wr_i ? ctl_mhre_i : mhre_q;
  assign cnt_a  = ctl_wr_i ? '0 : q_cnt;
  assign mask_a = ctl_wr_i ? '0 : q_mask;

  // then status write
  assign sta_clr  = sta_wr_i ? (status_q & ~sta_wdata_i) : status_q;
  assign fep_hit  = sta_clr[fep_o];
  assign do_clear = sta_wr_i && !fep_hit && (!mhre_a || cnt_a == '0);
  assign do_pop   = sta_wr_i && !fep_hit && mhre_a && cnt_a != '0;
  assign restore  = sta_wr_i && mhre_a && (do_pop || fep_hit);
  assign sta_b    = restore ? (sta_clr | mask_a) : sta_clr;
  assign fep_b    = do_pop ? head_idx : (do_clear ? '0 : fep_o);
  assign cnt_b    = cnt_a - CNT_W'(do_pop);

  // then record
  assign queue_hit = rec_valid_i && mhre_a && sta_b[fep_b];
  assign do_push   = queue_hit && (int'(cnt_b) < DEPTH);
  assign drop      = queue_hit && !(int'(cnt_b) < DEPTH);
  assign rec_log   = rec_valid_i && !queue_hit;

  assign ld_idx = rec_log ? rec_idx : head_idx;
  assign ld_pl  = rec_log ? rec_pl : head_pl;

  err_hdr_fifo #(.NUM_ERR(NUM_ERR), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (ctl_wr_i),
    .push_i      (do_push),
    .push_idx_i  (rec_idx),
    .push_pl_i   (rec_pl),
    .pop_i       (do_pop),
    .head_idx_o  (head_idx),
    .head_pl_o   (head_pl),
    .cnt_o       (q_cnt),
    .busy_mask_o (q_mask)
  );

  err_hdr_log_regs #(.IDX_W(IDX_W)) u_log (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (do_clear && !rec_log),
    .ld_i          (rec_log || do_pop),
    .ld_idx_i      (ld_idx),
    .ld_pl_i       (ld_pl),
    .pfx_en_i      (pfx_en_i),
    .fep_o         (fep_o),
    .hdr_o         (hdr_log_o),
    .pfx_o         (pfx_log_o),
    .pfx_present_o (pfx_present_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mhre_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      status_q <= rec_valid_i ? (sta_b | rec_status_i) : sta_b;
      mhre_q   <= mhre_a;
      ovf_q    <= drop;
    end
  end

  assign status_o   = status_q;
  assign mhre_o     = mhre_q;
  assign overflow_o = ovf_q;

  // R6
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(rec_valid_i && mhre_a));
  // R2
  rec_sta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |=> ((status_o & $past(rec_status_i)) == $past(rec_status_i)));
  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !rec_valid_i) |=> (q_cnt == '0));
  // R7
  clr_log_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_clear && !rec_valid_i) |=> (fep_o == '0 && hdr_log_o == '0 && !pfx_present_o));
endmodule

// File: tb/err_hdr_log_tb.sv
module err_hdr_log_tb;
  localparam int NE = 16;
  localparam int DP = 3;
  localparam int LW = 128;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          rec_valid = 0, rec_hdr_vld = 0, rec_pfx_vld = 0, pfx_en = 0;
  logic [NE-1:0] rec_status = '0, sta_wdata = '0;
  logic [LW-1:0] rec_hdr = '0, rec_pfx = '0;
  logic          sta_wr = 0, ctl_wr = 0, ctl_mhre = 0;

  logic [NE-1:0] status;
  logic          mhre, pfx_present, overflow;
  logic [3:0]    fep;
  logic [LW-1:0] hdr_log, pfx_log;

  err_hdr_log #(.NUM_ERR(NE), .DEPTH(DP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rec_valid_i(rec_valid), .rec_status_i(rec_status), .rec_hdr_i(rec_hdr),
    .rec_pfx_i(rec_pfx), .rec_hdr_vld_i(rec_hdr_vld), .rec_pfx_vld_i(rec_pfx_vld),
    .pfx_en_i(pfx_en), .sta_wr_i(sta_wr), .sta_wdata_i(sta_wdata),
    .ctl_wr_i(ctl_wr), .ctl_mhre_i(ctl_mhre),
    .status_o(status), .mhre_o(mhre), .fep_o(fep), .hdr_log_o(hdr_log),
    .pfx_log_o(pfx_log), .pfx_present_o(pfx_present), .overflow_o(overflow)
  );

  typedef struct {
    int            idx;
    logic [LW-1:0] h;
    logic [LW-1:0] p;
    bit            hv;
    bit            pv;
  } ent_t;

  ent_t          q[$];
  logic [NE-1:0] m_sta = '0;
  logic          m_mhre = 0, m_pp = 0, m_ovf = 0;
  int            m_fep = 0;
  logic [LW-1:0] m_hdr = '0, m_pfx = '0;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic load(input ent_t e);
    m_fep = e.idx;
    m_hdr = e.hv ? e.h : '0;
    if (e.pv && pfx_en) begin m_pfx = e.p; m_pp = 1; end
    else begin m_pfx = '0; m_pp = 0; end
  endtask

  task automatic model_step();
    logic [NE-1:0] sb;
    ent_t e;
    int lo;
    m_ovf = 0;
    if (ctl_wr) begin m_mhre = ctl_mhre; q.delete(); end
    sb = m_sta;
    if (sta_wr) begin
      sb = sb & ~sta_wdata;
      if (!sb[m_fep]) begin
        if (!m_mhre || q.size() == 0) begin
          m_fep = 0; m_hdr = '0; m_pfx = '0; m_pp = 0;
        end else begin
          foreach (q[i]) sb[q[i].idx] = 1'b1;
          e = q.pop_front();
          load(e);
        end
      end else if (m_mhre) begin
        foreach (q[i]) sb[q[i].idx] = 1'b1;
      end
    end
    if (rec_valid) begin
      lo = 0;
      for (int i = NE - 1; i >= 0; i--) if (rec_status[i]) lo = i;
      e.idx = lo; e.h = rec_hdr; e.p = rec_pfx; e.hv = rec_hdr_vld; e.pv = rec_pfx_vld;
      if (m_mhre && sb[m_fep]) begin
        if (q.size() == DP) m_ovf = 1;
        else q.push_back(e);
      end else load(e);
      sb = sb | rec_status;
    end
    m_sta = sb;
  endtask

  task automatic compare();
    bit bad = 0;
    n_cmp++;
    if (status !== m_sta) begin bad = 1; $display("FAIL %s status act=%h exp=%h", cur_req, status, m_sta); end
    if (mhre !== m_mhre) begin bad = 1; $display("FAIL %s mhre act=%b exp=%b", cur_req, mhre, m_mhre); end
    if (int'(fep) != m_fep || $isunknown(fep)) begin bad = 1; $display("FAIL %s fep act=%0d exp=%0d", cur_req, fep, m_fep); end
    if (hdr_log !== m_hdr) begin bad = 1; $display("FAIL %s hdr act=%h exp=%h", cur_req, hdr_log, m_hdr); end
    if (pfx_log !== m_pfx) begin bad = 1; $display("FAIL %s pfx act=%h exp=%h", cur_req, pfx_log, m_pfx); end
    if (pfx_present !== m_pp) begin bad = 1; $display("FAIL %s pfx_present act=%b exp=%b", cur_req, pfx_present, m_pp); end
    if (overflow !== m_ovf) begin bad = 1; $display("FAIL %s overflow act=%b exp=%b", cur_req, overflow, m_ovf); end
    if (bad) n_bad++;
  endtask

  // R12: model advances at the edge, outputs compared at the following falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    rec_valid = 0; sta_wr = 0; ctl_wr = 0;
  endtask

  task automatic rec(input int idx, input bit hv, input bit pv);
    rec_valid = 1; rec_status = NE'(1) << idx;
    rec_hdr = {$urandom, $urandom, $urandom, $urandom};
    rec_pfx = {$urandom, $urandom, $urandom, $urandom};
    rec_hdr_vld = hv; rec_pfx_vld = pv;
  endtask

  task automatic wr_sta(input logic [NE-1:0] m);
    sta_wr = 1; sta_wdata = m;
  endtask

  task automatic wr_ctl(input bit v);
    ctl_wr = 1; ctl_mhre = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1"; compare();
    rst_ni = 1;
    cyc(); compare();

    cur_req = "R2"; pfx_en = 1; rec(5, 1, 1); cyc();
    cur_req = "R3"; rec(9, 0, 1); cyc();
    cur_req = "R4"; pfx_en = 0; rec(2, 1, 1); cyc();
    pfx_en = 1; rec(12, 1, 0); cyc();
    cur_req = "R7"; wr_sta(NE'(1) << 12); cyc();

    cur_req = "R10"; wr_ctl(1); cyc();
    cur_req = "R5"; rec(3, 1, 1); cyc();
    rec(4, 1, 0); cyc();
    rec(6, 0, 1); cyc();
    rec(7, 1, 1); cyc();
    cur_req = "R6"; rec(8, 1, 1); cyc(); cyc();
    cur_req = "R9"; wr_sta(16'h00d0); cyc();
    cur_req = "R8"; wr_sta(16'h0008); cyc();
    wr_sta(16'h0010); cyc();
    cur_req = "R11"; wr_sta(16'h0040); rec(10, 1, 1); cyc();
    wr_ctl(1); wr_sta(16'h0080); rec(11, 1, 0); cyc();
    cur_req = "R10"; rec(13, 1, 1); cyc();
    wr_ctl(1); cyc();
    wr_sta(NE'(1) << fep); cyc();
    wr_ctl(0); rec(1, 1, 1); cyc();
    wr_sta('1); cyc();

    cur_req = "R11";
    for (int k = 0; k < 600; k++) begin
      pfx_en = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) rec(int'($urandom % NE), bit'($urandom % 2), bit'($urandom % 2));
      if ($urandom % 4 == 0) wr_sta(($urandom % 2) ? (NE'(1) << m_fep) : NE'($urandom));
      if ($urandom % 25 == 0) wr_ctl(($urandom % 4) != 0);
      cyc();
    end
    finish_run();
  end
endmodule